// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one complete I2C master transaction from a single packed command word. The word chooses the direction, the 7-bit target address, an 11-bit byte count and whether the transfer closes with a stop or keeps the bus for a repeated start. The engine produces the start condition and the address byte. It then moves data bytes from a transmit FIFO onto the bus, or from the bus into a receive FIFO. It finishes with a stop, or it parks the bus with SCL held low so that the next command begins with a repeated start.

Both bus lines are open-drain. The outputs `scl_oe` and `sda_oe` pull the line low when set, and the engine reads the real line levels back through `scl_in` and `sda_in`. Each bit lasts four quarter-phases of `QTR` clocks. The engine waits while a target holds SCL low. It detects lost arbitration and unexpected start or stop conditions, and it reports every outcome in a packed status word and as one-cycle event pulses.

Top module: `i2c_txn_master`

## Requirements
- R1: A command is taken only while `enable` is 1, the engine is idle or parked, and the address type field (`cmd_word[13:12]`) equals 1. Any other command is ignored: the bus lines stay released and the status does not change.
- R2: After the start condition, the first byte sent is `cmd_word[7:0]`, that is the address in bits 7:1 and the direction in bit 0 (0 write, 1 read), most significant bit first.
- R3: A write sends `cmd_word[25:15]` data bytes. Each byte is popped from the TX FIFO with `tx_pop`. While the FIFO is empty, SCL is held low and the engine waits.
- R4: A read receives its bytes most significant bit first and pushes each one on `rx_push`. The master ACKs every byte (SDA low) except the last, which it NACKs.
- R5: When `cmd_word[14]` is 1, a successful transfer ends with a stop condition and one `evt_done` pulse. A byte count of 0 sends the address only.
- R6: When `cmd_word[14]` is 0, a successful transfer raises `evt_done_nostop` and not `evt_done`, and leaves SCL held low with SDA released. The next command then begins with a repeated start.
- R7: If the address is NACKed, the engine aborts with cause 0. If a written data byte is NACKed, it aborts with cause 1. Both then issue a stop and pulse `evt_done`.
- R8: If SDA reads low while the master is sending a 1, arbitration is lost. The engine releases both lines, returns to idle, pulses `evt_arb_lost` and aborts with cause 3.
- R9: A change of SDA while SCL is high in the second half of a bit is an unexpected start or stop. The engine releases both lines, pulses `evt_bus_err` and aborts with cause 4.
- R10: The status word is laid out as follows: bits 1:0 hold the operation (0 write, 1 read); bits 3:2 hold the state (0 none, 1 in progress, 2 done, 3 aborted); bits 6:4 hold the abort cause; bits 19:9 hold the count of completed data bytes.
- R11: `busy` is 1 from the accepted command until the stop, the park or the abort. While idle, both line drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Peripheral enable; commands are taken only while it is high |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 26 | Packed command: direction, address, address type, stop, length |
| busy | output | 1 | Transaction in progress |
| tx_data | input | 8 | Head of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Takes the head byte of the transmit FIFO |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| status | output | 20 | Operation, state, abort cause and completed length |
| evt_done | output | 1 | Pulse: transaction closed with a stop |
| evt_done_nostop | output | 1 | Pulse: transaction closed with the bus held |
| evt_arb_lost | output | 1 | Pulse: arbitration lost |
| evt_bus_err | output | 1 | Pulse: unexpected start or stop seen |

## Verification
The assertions check several things on every cycle. At most one completion event fires at a time. A command is taken only with enable high. FIFO pops happen only on writes and pushes only on reads. Arbitration loss and bus errors leave the lines released and the abort cause set, and a parked bus keeps SCL low. Some behaviour can only be shown by the bench scenarios, because they need a target that responds on the wire: the bytes that cross the bus, the ACK/NACK pattern on reads, the repeated start after a park, the SCL stretch while the FIFO is empty, and the abort codes after a NACK.

// File: rtl/i2c_txn_master.sv
module i2c_txn_master #(
  parameter int QTR = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        cmd_valid,
  input  logic [25:0] cmd_word,
  output logic        busy,
  input  logic [7:0]  tx_data,
  input  logic        tx_empty,
  output logic        tx_pop,
  output logic [7:0]  rx_data,
  output logic        rx_push,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic [19:0] status,
  output logic        evt_done,
  output logic        evt_done_nostop,
  output logic        evt_arb_lost,
  output logic        evt_bus_err
);
  localparam int QW = $clog2(QTR + 1);
  localparam int LW = 11;

  typedef enum logic [2:0] {S_IDLE, S_START, S_LOAD, S_BIT, S_STOP, S_HOLD} st_t;
  st_t st;

  logic [QW-1:0] qcnt;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic [8:0]    sh;
  logic [7:0]    rsh;
  logic          is_rd, want_stop, addr_ph, rs, samp;
  logic [LW-1:0] len, done_cnt, cnt_n;
  logic [1:0]    op_st;
  logic [2:0]    cause;
  logic          unused_bits;

  assign unused_bits = ^cmd_word[11:8];

  wire tick   = (qcnt == QW'(QTR - 1));
  wire stall  = (st == S_BIT) && (q == 2'd2) && !scl_in;
  wire rdata  = is_rd && !addr_ph;
  wire last   = (done_cnt == len - LW'(1));
  wire mdrv   = (bitn < 4'd8) ? (rdata ? 1'b1 : sh[8]) : (rdata ? last : 1'b1);
  wire mtx    = (bitn < 4'd8) ? !rdata : rdata;
  wire accept = cmd_valid && enable && (st == S_IDLE || st == S_HOLD) && (cmd_word[13:12] == 2'd1);

  assign cnt_n  = done_cnt + LW'(!addr_ph);
  assign busy   = !(st == S_IDLE || st == S_HOLD);
  assign tx_pop = (st == S_LOAD) && !tx_empty;
  assign status = {done_cnt, 2'b00, cause, op_st, 1'b0, is_rd};

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin scl_oe = (q == 2'd0) ? rs : (q == 2'd3); sda_oe = q[1]; end
      S_LOAD, S_HOLD: scl_oe = 1'b1;
      S_BIT:   begin scl_oe = !q[1]; sda_oe = !mdrv; end
      S_STOP:  begin scl_oe = (q == 2'd0); sda_oe = !q[1]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; qcnt <= '0; q <= '0; bitn <= '0; sh <= '1; rsh <= '0;
      is_rd <= 1'b0; want_stop <= 1'b0; addr_ph <= 1'b0; rs <= 1'b0; samp <= 1'b1;
      len <= '0; done_cnt <= '0; op_st <= '0; cause <= '0; rx_data <= '0;
      rx_push <= 1'b0; evt_done <= 1'b0; evt_done_nostop <= 1'b0;
      evt_arb_lost <= 1'b0; evt_bus_err <= 1'b0;
    end else begin
      rx_push <= 1'b0; evt_done <= 1'b0; evt_done_nostop <= 1'b0;
      evt_arb_lost <= 1'b0; evt_bus_err <= 1'b0;
      if (st == S_START || st == S_BIT || st == S_STOP) begin
        if (!stall) begin
          if (tick) begin qcnt <= '0; q <= q + 2'd1; end
          else qcnt <= qcnt + QW'(1);
        end
      end else begin
        qcnt <= '0; q <= '0;
      end
      case (st)
        S_IDLE, S_HOLD: if (accept) begin
          st <= S_START; rs <= (st == S_HOLD);
          is_rd <= cmd_word[0]; want_stop <= cmd_word[14]; len <= cmd_word[25:15];
          done_cnt <= '0; cause <= '0; op_st <= 2'd1; sh <= {cmd_word[7:0], 1'b1};
        end
        S_START: if (tick && q == 2'd3) begin
          st <= S_BIT; bitn <= '0; addr_ph <= 1'b1;
        end
        S_LOAD: if (!tx_empty) begin
          sh <= {tx_data, 1'b1}; bitn <= '0; st <= S_BIT;
        end
        S_BIT: begin
          if (q == 2'd3 && sda_in != samp) begin
            st <= S_IDLE; op_st <= 2'd3; cause <= 3'd4; evt_bus_err <= 1'b1;
          end else if (tick && q == 2'd2 && !stall) begin
            samp <= sda_in;
            if (mtx && mdrv && !sda_in) begin
              st <= S_IDLE; op_st <= 2'd3; cause <= 3'd3; evt_arb_lost <= 1'b1;
            end
          end else if (tick && q == 2'd3) begin
            sh   <= {sh[7:0], 1'b1};
            bitn <= bitn + 4'd1;
            if (bitn < 4'd8) rsh <= {rsh[6:0], samp};
            else begin
              bitn <= '0;
              if (!rdata && samp) begin
                op_st <= 2'd3; cause <= addr_ph ? 3'd0 : 3'd1; st <= S_STOP;
              end else begin
                addr_ph  <= 1'b0;
                done_cnt <= cnt_n;
                if (rdata) begin rx_push <= 1'b1; rx_data <= rsh; end
                if (cnt_n == len) begin
                  if (want_stop) st <= S_STOP;
                  else begin st <= S_HOLD; op_st <= 2'd2; evt_done_nostop <= 1'b1; end
                end else if (!is_rd) st <= S_LOAD;
              end
            end
          end
        end
        S_STOP: if (tick && q == 2'd3) begin
          st <= S_IDLE; evt_done <= 1'b1;
          if (op_st != 2'd3) op_st <= 2'd2;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_start_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable));
  assert_pop_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (busy && !status[0]));
  assert_push_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> status[0]);
  assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_done, evt_done_nostop, evt_arb_lost, evt_bus_err}));
  assert_park_holds_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done_nostop |-> (scl_oe && !sda_oe && !busy));
  assert_arb_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_arb_lost |-> (status[3:2] == 2'd3 && status[6:4] == 3'd3 && !scl_oe && !sda_oe));
  assert_berr_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bus_err |-> (!scl_oe && !sda_oe && status[6:4] == 3'd4));
  assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_oe && !sda_oe && !busy));
endmodule

// File: tb/sim_i2c_txn_master.sv
module sim_i2c_txn_master;
  logic clk = 0, rst_n = 0, enable = 0, cmd_valid = 0;
  logic [25:0] cmd_word = '0;
  logic busy, tx_empty, tx_pop, rx_push, scl_oe, sda_oe;
  logic evt_done, evt_done_nostop, evt_arb_lost, evt_bus_err;
  logic [7:0] tx_data, rx_data;
  logic [19:0] status;
  logic scl_line, sda_line;
  logic tgt_low = 0, arb_low = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe | tgt_low | arb_low);

  i2c_txn_master #(.QTR(4)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .busy(busy), .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status), .evt_done(evt_done),
    .evt_done_nostop(evt_done_nostop), .evt_arb_lost(evt_arb_lost), .evt_bus_err(evt_bus_err));

  logic [7:0] txq [16];
  int tx_wr = 0, tx_rd = 0;
  assign tx_empty = (tx_wr == tx_rd);
  assign tx_data  = txq[tx_rd % 16];
  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

  logic [7:0] rx_log [16];
  int rx_n = 0;
  always @(negedge clk) if (rx_push) begin rx_log[rx_n % 16] = rx_data; rx_n++; end

  function automatic logic [7:0] rd_byte(input int k);
    return 8'hC3 ^ 8'(k * 37);
  endfunction

  // target model
  int cnt = -1, bidx = 0, wr_n = 0, mack_n = 0, nack_at = -1;
  bit act = 0, rdm = 0, ph_addr = 1, rd_on = 0, ack_addr = 1;
  logic [7:0] tsh = '0, tb_b = '0;
  logic [7:0] wr_log [16];
  logic mack_log [16];

  always @(negedge sda_line) if (scl_line) begin
    act = 1; cnt = -1; ph_addr = 1; rdm = 0; rd_on = 0; bidx = 0; tgt_low = 0;
  end
  always @(posedge sda_line) if (scl_line) begin act = 0; tgt_low = 0; end
  always @(posedge scl_line) if (act) begin
    if (cnt >= 0 && cnt < 8) tsh = {tsh[6:0], sda_line};
    else if (cnt == 8 && rdm && !ph_addr) begin
      if (mack_n < 16) mack_log[mack_n] = sda_line;
      mack_n++;
      if (sda_line) rd_on = 0;
    end
  end
  always @(negedge scl_line) if (act) begin
    cnt = cnt + 1;
    if (cnt == 9) begin
      cnt = 0;
      if (ph_addr) begin ph_addr = 0; rdm = tsh[0]; rd_on = tsh[0]; end
      else bidx = bidx + 1;
    end
    if (cnt == 8) begin
      if (ph_addr || !rdm) begin
        if (wr_n < 16) wr_log[wr_n] = tsh;
        wr_n++;
        tgt_low = ph_addr ? ack_addr : (bidx != nack_at);
      end else tgt_low = 0;
    end else if (rdm && !ph_addr && rd_on) begin
      tb_b = rd_byte(bidx);
      tgt_low = !tb_b[7 - cnt];
    end else tgt_low = 0;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [19:0] exp_st(input int n, input int c, input int s, input int op);
    return {11'(n), 2'b00, 3'(c), 2'(s), 1'b0, 1'(op)};
  endfunction

  function automatic logic [25:0] mk(input bit rd, input logic [6:0] a, input bit stp, input int n);
    return {11'(n), stp, 2'b01, 4'b0000, a, rd};
  endfunction

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); txq[tx_wr % 16] = b; tx_wr++;
  endtask

  task automatic send(input logic [25:0] w);
    @(negedge clk); cmd_word = w; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wait_evt(output logic [3:0] ev);
    ev = 4'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (evt_done | evt_done_nostop | evt_arb_lost | evt_bus_err) begin
        ev = {evt_done, evt_done_nostop, evt_arb_lost, evt_bus_err};
        break;
      end
    end
  endtask

  task automatic clear_logs();
    wr_n = 0; mack_n = 0; rx_n = 0; ack_addr = 1; nack_at = -1;
  endtask

  task automatic t_reset();
    chk("R11", "reset busy", 32'(busy), 0);
    chk("R11", "reset lines", {scl_oe, sda_oe}, 0);
    chk("R10", "reset status", 32'(status), 0);
  endtask

  task automatic t_ignored();
    enable = 0;
    send(mk(0, 7'h2A, 1, 1));
    repeat (50) @(negedge clk);
    chk("R1", "disabled: busy", 32'(busy), 0);
    chk("R1", "disabled: scl", 32'(scl_line), 1);
    chk("R1", "disabled: status", 32'(status), 0);
    enable = 1;
    send({11'd1, 1'b1, 2'b10, 4'b0, 7'h2A, 1'b0});
    repeat (50) @(negedge clk);
    chk("R1", "bad type: busy", 32'(busy), 0);
    chk("R1", "bad type: sda", 32'(sda_line), 1);
    chk("R1", "bad type: status", 32'(status), 0);
  endtask

  task automatic t_write();
    logic [3:0] ev;
    clear_logs();
    push_tx(8'h12); push_tx(8'hA7); push_tx(8'h3C);
    send(mk(0, 7'h2A, 1, 3));
    chk("R11", "busy after accept", 32'(busy), 1);
    chk("R10", "in-progress state", 32'(status[3:2]), 1);
    wait_evt(ev);
    chk("R5", "write event", 32'(ev), 32'b1000);
    chk("R10", "write status", 32'(status), 32'(exp_st(3, 0, 2, 0)));
    chk("R2", "address byte", 32'(wr_log[0]), 32'h54);
    chk("R3", "data 0", 32'(wr_log[1]), 32'h12);
    chk("R3", "data 1", 32'(wr_log[2]), 32'hA7);
    chk("R3", "data 2", 32'(wr_log[3]), 32'h3C);
    chk("R3", "fifo drained", 32'(tx_empty), 1);
    repeat (4) @(negedge clk);
    chk("R11", "idle after stop", {busy, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_read();
    logic [3:0] ev;
    clear_logs();
    send(mk(1, 7'h35, 1, 3));
    wait_evt(ev);
    chk("R5", "read event", 32'(ev), 32'b1000);
    chk("R10", "read status", 32'(status), 32'(exp_st(3, 0, 2, 1)));
    chk("R2", "read address byte", 32'(wr_log[0]), 32'h6B);
    chk("R4", "rx count", 32'(rx_n), 3);
    for (int k = 0; k < 3; k++) chk("R4", "rx byte", 32'(rx_log[k]), 32'(rd_byte(k)));
    chk("R4", "ack pattern", {mack_log[0], mack_log[1], mack_log[2]}, 32'b001);
  endtask

  task automatic t_park_restart();
    logic [3:0] ev;
    clear_logs();
    push_tx(8'h77);
    send(mk(0, 7'h21, 0, 1));
    wait_evt(ev);
    chk("R6", "nostop event", 32'(ev), 32'b0100);
    chk("R6", "park status", 32'(status), 32'(exp_st(1, 0, 2, 0)));
    repeat (40) @(negedge clk);
    chk("R6", "scl held low", 32'(scl_line), 0);
    chk("R6", "sda released", 32'(sda_line), 1);
    send(mk(1, 7'h21, 1, 2));
    wait_evt(ev);
    chk("R6", "restart event", 32'(ev), 32'b1000);
    chk("R6", "restart address", 32'(wr_log[2]), 32'h43);
    chk("R4", "restart rx 0", 32'(rx_log[0]), 32'(rd_byte(0)));
    chk("R4", "restart rx 1", 32'(rx_log[1]), 32'(rd_byte(1)));
  endtask

  task automatic t_nacks();
    logic [3:0] ev;
    clear_logs();
    ack_addr = 0;
    send(mk(1, 7'h11, 1, 1));
    wait_evt(ev);
    chk("R7", "addr nack event", 32'(ev), 32'b1000);
    chk("R7", "addr nack status", 32'(status), 32'(exp_st(0, 0, 3, 1)));
    chk("R7", "addr nack no rx", 32'(rx_n), 0);
    clear_logs();
    nack_at = 1;
    push_tx(8'h01); push_tx(8'h02);
    send(mk(0, 7'h11, 1, 2));
    wait_evt(ev);
    chk("R7", "data nack event", 32'(ev), 32'b1000);
    chk("R7", "data nack status", 32'(status), 32'(exp_st(1, 1, 3, 0)));
  endtask

  task automatic t_stretch();
    logic [3:0] ev;
    clear_logs();
    send(mk(0, 7'h0F, 1, 1));
    repeat (400) @(negedge clk);
    chk("R3", "stretch scl low", 32'(scl_line), 0);
    chk("R3", "stretch busy", 32'(busy), 1);
    chk("R3", "stretch length", 32'(status[19:9]), 0);
    push_tx(8'h5A);
    wait_evt(ev);
    chk("R3", "stretch event", 32'(ev), 32'b1000);
    chk("R3", "stretch data", 32'(wr_log[1]), 32'h5A);
  endtask

  task automatic t_len0();
    logic [3:0] ev;
    clear_logs();
    send(mk(0, 7'h44, 1, 0));
    wait_evt(ev);
    chk("R5", "len0 event", 32'(ev), 32'b1000);
    chk("R5", "len0 status", 32'(status), 32'(exp_st(0, 0, 2, 0)));
    chk("R5", "len0 bytes on bus", 32'(wr_n), 1);
  endtask

  task automatic t_arb();
    logic [3:0] ev;
    clear_logs();
    @(negedge clk); arb_low = 1;
    send(mk(0, 7'h50, 1, 1));
    wait_evt(ev);
    chk("R8", "arb event", 32'(ev), 32'b0010);
    chk("R8", "arb status", 32'(status), 32'(exp_st(0, 3, 3, 0)));
    @(negedge clk);
    chk("R8", "arb lines released", {scl_oe, sda_oe, busy}, 0);
    arb_low = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_berr();
    logic [3:0] ev;
    clear_logs();
    push_tx(8'hFF);
    send(mk(0, 7'h2A, 1, 1));
    repeat (10) @(posedge scl_line);
    #25 arb_low = 1;
    wait_evt(ev);
    chk("R9", "berr event", 32'(ev), 32'b0001);
    chk("R9", "berr status", 32'(status), 32'(exp_st(0, 4, 3, 0)));
    @(negedge clk);
    chk("R9", "berr lines released", {scl_oe, sda_oe, busy}, 0);
    arb_low = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_ignored();
    t_write();
    t_read();
    t_park_restart();
    t_nacks();
    t_stretch();
    t_len0();
    t_arb();
    t_berr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule